// File: doc/BRIEF.md
# Bridge Configuration Header Registers

This block holds two configuration registers for a bus bridge that follows PCI conventions: the 16-bit Command register and the 8-bit Latency Timer. Two sources can change them. A remote host updates them through a configuration-write port that has per-byte enables. On that path only a fixed set of Command bits can change, and the Latency Timer takes any byte value. A local self-configuration strobe loads a preset operating value into both registers at once. A later remote write can still overwrite that preset.

The local side reads the registers through a one-cycle read port. The result comes back byte-swapped relative to the register's native bit order, which keeps byte addressing consistent on the local bus. The register values are also driven straight out as outputs that control bridge behaviour.

Top module: `bcfg_hdr_regs`

## Requirements
- R1: While `rst_n` is low, `cmd_reg` is 0x0000, `lat_reg` is 0x00 and `loc_rd_vld` is 0.
- R2: A remote write to the Command register (`rmt_wr_sel`=0, both byte enables set) stores `rmt_wr_data & 0x0546` on the following clock edge. Bit 0 (I/O enable) and bit 7 can never be set this way, and every bit outside the mask reads as zero. For example, 0xFFFF stores 0x0546, 0x0086 stores 0x0006 and 0x0001 stores 0x0000.
- R3: `rmt_wr_be[0]` gates bits 7:0 and `rmt_wr_be[1]` gates bits 15:8 of a Command write. A lane whose enable is 0 keeps its previous contents.
- R4: A remote write to the Latency Timer (`rmt_wr_sel`=1) with `rmt_wr_be[0]`=1 stores `rmt_wr_data[7:0]` unchanged, including 0x00, 0x01 and 0xFF. With `rmt_wr_be[0]`=0 the register keeps its value.
- R5: A `self_cfg` pulse loads 0x0546 into `cmd_reg` and 0xFF into `lat_reg` on the next edge, whatever they held before.
- R6: When a remote write and `self_cfg` occur in the same cycle, the preset values of R5 are stored and the remote data is discarded.
- R7: After self-configuration, a remote write moves either register to a new value under the rules of R2 to R4.
- R8: A local read request (`loc_rd_en`=1) in cycle N raises `loc_rd_vld` in cycle N+1 and returns register contents as they stood in cycle N, before any update in that cycle. `loc_rd_sel`=0 returns the Command register with its two bytes swapped, `{cmd[7:0], cmd[15:8]}`. `loc_rd_sel`=1 returns `{8'h00, lat}`. Without a request, `loc_rd_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rmt_wr_en | input | 1 | Remote configuration write strobe |
| rmt_wr_sel | input | 1 | Remote write target: 0 Command, 1 Latency Timer |
| rmt_wr_data | input | 16 | Remote write data in native bit order |
| rmt_wr_be | input | 2 | Remote write byte enables, bit i gates byte i |
| self_cfg | input | 1 | Self-configuration strobe that loads the presets |
| loc_rd_en | input | 1 | Local read request |
| loc_rd_sel | input | 1 | Local read target: 0 Command, 1 Latency Timer |
| loc_rd_vld | output | 1 | Local read data valid, one cycle after the request |
| loc_rd_data | output | 16 | Local read data in byte-swapped order |
| cmd_reg | output | 16 | Current Command register, native order |
| lat_reg | output | 8 | Current Latency Timer register |

## Verification
A remote write or self-configuration in cycle N shows on `cmd_reg` and `lat_reg` right after the edge that ends cycle N. The bench drives each stimulus on a falling edge, removes it shortly after the next rising edge, and compares the register outputs at that point against its own model. Read data is due one edge after the request. The driver pushes the swapped model value, taken before the same cycle's update, into a queue, and a monitor compares it on the falling edge where `loc_rd_vld` is high. Cases where a read and a write land in the same cycle confirm that the read returns the old value.

// File: rtl/bcfg_pkg.sv
package bcfg_pkg;
    localparam int LANE_W     = 8;
    localparam int CMD_W      = 16;
    localparam int LAT_W      = 8;
    localparam int CMD_LANES  = CMD_W / LANE_W;
    localparam int LAT_LANES  = LAT_W / LANE_W;
    localparam int RD_W       = CMD_W;

    // Bits a remote initiator may change in the Command register (native order)
    localparam logic [CMD_W-1:0] CMD_WR_MASK  = 16'h0546;
    // Values loaded by a self-configuration event
    localparam logic [CMD_W-1:0] CMD_PRESET   = 16'h0546;
    localparam logic [LAT_W-1:0] LAT_PRESET   = 8'hFF;
    localparam logic [LAT_W-1:0] LAT_WR_MASK  = {LAT_W{1'b1}};

    typedef enum logic {
        SEL_CMD = 1'b0,
        SEL_LAT = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic [CMD_W-1:0] cmd;
        logic [LAT_W-1:0] lat;
        logic [RD_W-1:0]  rd_data;
        logic             rd_vld;
    } hdr_state_t;
endpackage

// File: rtl/bcfg_lane_merge.sv
// Per-lane masked merge of incoming write data into a register.
module bcfg_lane_merge #(
    parameter int LANES  = 2,
    parameter int LANE_W = 8,
    localparam int W     = LANES * LANE_W
) (
    input  logic [W-1:0]     old_val,
    input  logic [W-1:0]     wr_val,
    input  logic [LANES-1:0] lane_en,
    input  logic [W-1:0]     wr_mask,
    output logic [W-1:0]     merged
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb begin
            if (lane_en[g]) begin
                merged[g*LANE_W +: LANE_W] = wr_val[g*LANE_W +: LANE_W]
                                           & wr_mask[g*LANE_W +: LANE_W];
            end else begin
                merged[g*LANE_W +: LANE_W] = old_val[g*LANE_W +: LANE_W];
            end
        end
    end
endmodule

// File: rtl/bcfg_byte_swap.sv
// Reverses the byte order of a word for the local-side view.
module bcfg_byte_swap #(
    parameter int LANES  = 2,
    parameter int LANE_W = 8,
    localparam int W     = LANES * LANE_W
) (
    input  logic [W-1:0] native,
    output logic [W-1:0] swapped
);
    for (genvar g = 0; g < LANES; g++) begin : g_swap
        assign swapped[g*LANE_W +: LANE_W] = native[(LANES-1-g)*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/bcfg_hdr_regs.sv
module bcfg_hdr_regs
    import bcfg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rmt_wr_en,
    input  logic                 rmt_wr_sel,
    input  logic [CMD_W-1:0]     rmt_wr_data,
    input  logic [CMD_LANES-1:0] rmt_wr_be,
    input  logic                 self_cfg,
    input  logic                 loc_rd_en,
    input  logic                 loc_rd_sel,
    output logic                 loc_rd_vld,
    output logic [RD_W-1:0]      loc_rd_data,
    output logic [CMD_W-1:0]     cmd_reg,
    output logic [LAT_W-1:0]     lat_reg
);
    hdr_state_t state_d, state_q;

    logic [CMD_W-1:0]     cmd_merged;
    logic [LAT_W-1:0]     lat_merged;
    logic [CMD_W-1:0]     cmd_swapped;
    logic [CMD_LANES-1:0] cmd_lane_en;
    logic [LAT_LANES-1:0] lat_lane_en;

    assign cmd_lane_en = (rmt_wr_en && reg_sel_e'(rmt_wr_sel) == SEL_CMD)
                         ? rmt_wr_be : '0;
    assign lat_lane_en = (rmt_wr_en && reg_sel_e'(rmt_wr_sel) == SEL_LAT)
                         ? rmt_wr_be[LAT_LANES-1:0] : '0;

    bcfg_lane_merge #(.LANES(CMD_LANES), .LANE_W(LANE_W)) u_cmd_merge (
        .old_val (state_q.cmd),
        .wr_val  (rmt_wr_data),
        .lane_en (cmd_lane_en),
        .wr_mask (CMD_WR_MASK),
        .merged  (cmd_merged)
    );

    bcfg_lane_merge #(.LANES(LAT_LANES), .LANE_W(LANE_W)) u_lat_merge (
        .old_val (state_q.lat),
        .wr_val  (rmt_wr_data[LAT_W-1:0]),
        .lane_en (lat_lane_en),
        .wr_mask (LAT_WR_MASK),
        .merged  (lat_merged)
    );

    bcfg_byte_swap #(.LANES(CMD_LANES), .LANE_W(LANE_W)) u_cmd_swap (
        .native  (state_q.cmd),
        .swapped (cmd_swapped)
    );

    always_comb begin
        state_d        = state_q;
        state_d.rd_vld = loc_rd_en;
        if (loc_rd_en) begin
            if (reg_sel_e'(loc_rd_sel) == SEL_CMD) begin
                state_d.rd_data = cmd_swapped;
            end else begin
                state_d.rd_data = {{(RD_W-LAT_W){1'b0}}, state_q.lat};
            end
        end
        if (self_cfg) begin
            state_d.cmd = CMD_PRESET;
            state_d.lat = LAT_PRESET;
        end else begin
            state_d.cmd = cmd_merged;
            state_d.lat = lat_merged;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign loc_rd_vld  = state_q.rd_vld;
    assign loc_rd_data = state_q.rd_data;
    assign cmd_reg     = state_q.cmd;
    assign lat_reg     = state_q.lat;
endmodule

// File: rtl/bcfg_hdr_regs_chk.sv
module bcfg_hdr_regs_chk
    import bcfg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rmt_wr_en,
    input  logic                 rmt_wr_sel,
    input  logic [CMD_W-1:0]     rmt_wr_data,
    input  logic [CMD_LANES-1:0] rmt_wr_be,
    input  logic                 self_cfg,
    input  logic                 loc_rd_en,
    input  logic                 loc_rd_vld,
    input  logic [CMD_W-1:0]     cmd_reg,
    input  logic [LAT_W-1:0]     lat_reg
);
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |-> (cmd_reg == '0 && lat_reg == '0 && !loc_rd_vld));

    a_r2_mask_only: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_reg & ~CMD_WR_MASK) == '0);

    a_r2_full_write: assert property (@(posedge clk) disable iff (!rst_n)
        (rmt_wr_en && !rmt_wr_sel && rmt_wr_be == '1 && !self_cfg)
        |=> cmd_reg == ($past(rmt_wr_data) & CMD_WR_MASK));

    a_r3_hi_lane_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rmt_wr_en && !rmt_wr_sel && !rmt_wr_be[1] && !self_cfg)
        |=> cmd_reg[CMD_W-1:LANE_W] == $past(cmd_reg[CMD_W-1:LANE_W]));

    a_r4_lat_write: assert property (@(posedge clk) disable iff (!rst_n)
        (rmt_wr_en && rmt_wr_sel && rmt_wr_be[0] && !self_cfg)
        |=> lat_reg == $past(rmt_wr_data[LAT_W-1:0]));

    a_r5_r6_preset: assert property (@(posedge clk) disable iff (!rst_n)
        self_cfg |=> (cmd_reg == CMD_PRESET && lat_reg == LAT_PRESET));

    a_r8_rd_valid: assert property (@(posedge clk) disable iff (!rst_n)
        loc_rd_en |=> loc_rd_vld);

    a_r8_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !loc_rd_en |=> !loc_rd_vld);
endmodule

bind bcfg_hdr_regs bcfg_hdr_regs_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rmt_wr_en   (rmt_wr_en),
    .rmt_wr_sel  (rmt_wr_sel),
    .rmt_wr_data (rmt_wr_data),
    .rmt_wr_be   (rmt_wr_be),
    .self_cfg    (self_cfg),
    .loc_rd_en   (loc_rd_en),
    .loc_rd_vld  (loc_rd_vld),
    .cmd_reg     (cmd_reg),
    .lat_reg     (lat_reg)
);

// File: tb/bcfg_hdr_regs_tb.sv
module bcfg_hdr_regs_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rmt_wr_en = 1'b0;
    logic        rmt_wr_sel = 1'b0;
    logic [15:0] rmt_wr_data = '0;
    logic [1:0]  rmt_wr_be = '0;
    logic        self_cfg = 1'b0;
    logic        loc_rd_en = 1'b0;
    logic        loc_rd_sel = 1'b0;
    logic        loc_rd_vld;
    logic [15:0] loc_rd_data;
    logic [15:0] cmd_reg;
    logic [7:0]  lat_reg;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc_cnt = 0;
    logic done = 1'b0;

    logic [15:0] m_cmd = '0;
    logic [7:0]  m_lat = '0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    bcfg_hdr_regs u_dut (
        .clk(clk), .rst_n(rst_n),
        .rmt_wr_en(rmt_wr_en), .rmt_wr_sel(rmt_wr_sel),
        .rmt_wr_data(rmt_wr_data), .rmt_wr_be(rmt_wr_be),
        .self_cfg(self_cfg), .loc_rd_en(loc_rd_en), .loc_rd_sel(loc_rd_sel),
        .loc_rd_vld(loc_rd_vld), .loc_rd_data(loc_rd_data),
        .cmd_reg(cmd_reg), .lat_reg(lat_reg)
    );

    always #4 clk = ~clk;

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
        end
    endtask

    task automatic check_regs(input string tag);
        check({tag, " cmd"}, cmd_reg, m_cmd);
        check({tag, " lat"}, {8'h00, lat_reg}, {8'h00, m_lat});
    endtask

    // Driver: applies one cycle of stimulus and predicts results
    task automatic step(input logic we, input logic wsel, input logic [15:0] wd,
                        input logic [1:0] be, input logic sc,
                        input logic re, input logic rsel, input string tag);
        @(negedge clk);
        rmt_wr_en = we; rmt_wr_sel = wsel; rmt_wr_data = wd; rmt_wr_be = be;
        self_cfg = sc; loc_rd_en = re; loc_rd_sel = rsel;
        if (re) begin
            exp_q.push_back(rsel ? {8'h00, m_lat} : {m_cmd[7:0], m_cmd[15:8]});
            tag_q.push_back(tag);
        end
        if (sc) begin
            m_cmd = 16'h0546;
            m_lat = 8'hFF;
        end else if (we && !wsel) begin
            if (be[0]) m_cmd[7:0]  = wd[7:0]  & 8'h46;
            if (be[1]) m_cmd[15:8] = wd[15:8] & 8'h05;
        end else if (we && wsel && be[0]) begin
            m_lat = wd[7:0];
        end
        @(posedge clk);
        #1;
        rmt_wr_en = 1'b0; self_cfg = 1'b0; loc_rd_en = 1'b0;
    endtask

    // Monitor: compares read results as they appear
    always @(negedge clk) begin
        if (rst_n && loc_rd_vld) begin
            if (exp_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R8: unexpected read valid, actual 0x%04h expected none", loc_rd_data);
            end else begin
                check(tag_q.pop_front(), loc_rd_data, exp_q.pop_front());
            end
        end
    end

    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 5000 && !done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset cmd", cmd_reg, 16'h0000);
        check("R1 reset lat", {8'h00, lat_reg}, 16'h0000);
        check("R1 reset vld", {15'h0, loc_rd_vld}, 16'h0000);
        rst_n = 1'b1;
        step(0, 0, 16'h0, 2'b00, 0, 1, 0, "R1 R8 read cmd after reset");
        step(1, 0, 16'hFFFF, 2'b11, 0, 0, 0, "R2");   check_regs("R2 write FFFF");
        step(0, 0, 16'h0, 2'b00, 0, 1, 0, "R8 swapped cmd 4605");
        step(1, 0, 16'h0000, 2'b11, 0, 0, 0, "R2");   check_regs("R2 write 0000");
        step(1, 0, 16'h0086, 2'b11, 0, 0, 0, "R2");   check_regs("R2 bit7 blocked");
        step(1, 0, 16'h0001, 2'b11, 0, 0, 0, "R2");   check_regs("R2 io bit blocked");
        step(1, 0, 16'h0400, 2'b11, 0, 0, 0, "R2");   check_regs("R2 write 0400");
        step(1, 0, 16'hFFFF, 2'b11, 0, 0, 0, "R3");
        step(1, 0, 16'h0000, 2'b01, 0, 0, 0, "R3");   check_regs("R3 low lane only");
        step(1, 0, 16'h0000, 2'b00, 0, 0, 0, "R3");   check_regs("R3 no lanes");
        step(1, 0, 16'hFFFF, 2'b10, 0, 0, 0, "R3");   check_regs("R3 high lane only");
        step(1, 1, 16'h0000, 2'b01, 0, 0, 0, "R4");   check_regs("R4 lat 00");
        step(1, 1, 16'h0001, 2'b01, 0, 0, 0, "R4");   check_regs("R4 lat 01");
        step(1, 1, 16'h00FF, 2'b01, 0, 0, 0, "R4");   check_regs("R4 lat FF");
        step(1, 1, 16'h0033, 2'b10, 0, 0, 0, "R4");   check_regs("R4 lat be0 off");
        step(1, 1, 16'h5A5A, 2'b11, 0, 1, 1, "R8 read lat");
        check_regs("R4 lat 5A");
        step(0, 0, 16'h0, 2'b00, 0, 1, 1, "R8 read lat 5A");
        step(0, 0, 16'h0, 2'b00, 1, 0, 0, "R5");      check_regs("R5 self config");
        step(1, 0, 16'h0004, 2'b11, 0, 0, 0, "R7");   check_regs("R7 cmd overwrite");
        step(1, 1, 16'h0001, 2'b01, 0, 0, 0, "R7");   check_regs("R7 lat overwrite");
        step(1, 0, 16'h0000, 2'b11, 1, 0, 0, "R6");   check_regs("R6 cmd collision");
        step(1, 1, 16'h0000, 2'b01, 1, 0, 0, "R6");   check_regs("R6 lat collision");
        step(1, 0, 16'h0002, 2'b11, 0, 1, 0, "R8 read before write");
        check_regs("R8 write with read");
        step(0, 0, 16'h0, 2'b00, 0, 1, 0, "R8 read 0002 swapped");
        repeat (3) @(negedge clk);
        check("R8 queue drained", 16'(exp_q.size()), 16'h0000);
        check("R8 vld idle", {15'h0, loc_rd_vld}, 16'h0000);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule